// File: doc/BRIEF.md
# Parallel Flash Bank Eraser and Programmer

This block rewrites one bank of a byte-wide parallel flash. It takes a start pulse and a bank number, then runs the whole job without further help. It erases the bank and checks that every byte reads back as 0xFF. It then programs the bank one byte at a time from an image source that the block addresses itself, and reads the bank back against that image. The flash accepts a command only after a two-write unlock pattern. It has no status register: while an erase or program is running, two back-to-back reads of the bank base return different values.

Every command write is followed by a programmable idle gap, given as a clock count derived from the clock frequency and the required spacing. After each erase or byte program the block polls the bank base. If the flash stays busy past a limit, the block raises a timeout and stops the remaining work. After the erase phase and after the program phase, the block writes a reset code to the bank base. A caller starts a job, waits for the one-cycle done pulse, and then reads the timeout and verify-failure flags. Both flags stay valid until the next start.

Top module: `flash_bank_prog`

## Requirements
- R1: Each erase setup write (0x80 to offset 0x555) and each program setup write (0xA0 to offset 0x555) comes straight after two writes: 0xAA to offset 0x555, then 0x55 to offset 0x2AA.
- R2: A job begins with the six-write erase: unlock, then 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and 0x30 to bank offset 0. The erase leaves the selected bank all 0xFF before any byte is programmed.
- R3: Each image byte i, for i from 0 to BANK_BYTES-1, is programmed as follows: unlock, then 0xA0 to 0x555, then the image byte to offset i. Every flash access carries the bank number latched at start in the address bits above the offset, and the other bank is left untouched.
- R4: Two consecutive write strobes are at least GAP_CYCLES clock cycles apart.
- R5: After an erase or program data write, the block issues no further write until two successive reads of the bank base return equal values. The read and write strobes are never high together.
- R6: If POLL_LIMIT consecutive read pairs differ, timeout_o is set and the block stops polling. In the program phase, no further bytes are programmed.
- R7: After the erase phase, and after the program phase (including an aborted one), the block writes 0xF0 to bank offset 0 and then waits one gap before reading back.
- R8: After the erase, every byte of the bank is read back. Any byte other than 0xFF sets verify_fail_o, and the program phase is then skipped.
- R9: After the program phase, every byte is read back and compared with the image. Any mismatch sets verify_fail_o.
- R10: done_o pulses for exactly one cycle at the end of a job. busy_o is high from the cycle after an accepted start until done. A start while busy is ignored. Both flags clear on an accepted start. When the block is not busy, no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| bank_i | input | BSW | Bank to rewrite, latched at start |
| img_addr_o | output | BW | Image byte index being requested |
| img_data_i | input | 8 | Image byte at img_addr_o, same cycle |
| fl_addr_o | output | BSW+AW | Flash address: bank above offset |
| fl_wdata_o | output | 8 | Flash write data |
| fl_we_o | output | 1 | Write strobe, one cycle per write |
| fl_oe_o | output | 1 | Read strobe; fl_rdata_i sampled at that edge |
| fl_rdata_i | input | 8 | Flash read data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| timeout_o | output | 1 | A poll exceeded POLL_LIMIT during the last job |
| verify_fail_o | output | 1 | Read-back mismatch during the last job |

## Verification
On every cycle the assertions check the following properties:
- the unlock pair that precedes each setup write;
- the minimum spacing between writes;
- the latched bank on every access;
- mutually exclusive strobes;
- silence while idle;
- the single-cycle done pulse.

Other behaviours can only be shown by the bench's flash model and scenarios:
- The true erase and program contents, and an untouched other bank.
- No write is issued while the model is still toggling.
- The number of reset writes.
- Programming stops exactly at the byte that hung.
- The program phase is skipped after a failed erase.
- Mismatches are detected on read-back.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_GAP, ST_POLL_A, ST_POLL_B, ST_VERIFY, ST_DONE
  } state_e;

  typedef enum logic [1:0] {SEQ_ERASE, SEQ_PROG, SEQ_RESET} seq_e;

  localparam logic [11:0] OFF_UL_A = 12'h555;
  localparam logic [11:0] OFF_UL_B = 12'h2AA;
  localparam logic [7:0]  D_UL_A   = 8'hAA;
  localparam logic [7:0]  D_UL_B   = 8'h55;
  localparam logic [7:0]  D_ER_SET = 8'h80;
  localparam logic [7:0]  D_ER_GO  = 8'h30;
  localparam logic [7:0]  D_PG_SET = 8'hA0;
  localparam logic [7:0]  D_RESET  = 8'hF0;
  localparam logic [7:0]  D_BLANK  = 8'hFF;
endpackage

// File: rtl/fbp_cmd_seq.sv
module fbp_cmd_seq
  import fbp_pkg::*;
#(
  parameter int AW = 13
) (
  input  seq_e          seq_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          last_o
);
  localparam logic [AW-1:0] A_UL_A = AW'(OFF_UL_A);
  localparam logic [AW-1:0] A_UL_B = AW'(OFF_UL_B);

  always_comb begin
    addr_o = '0;
    data_o = D_RESET;
    last_o = 1'b1;
    unique case (seq_i)
      SEQ_ERASE: begin
        last_o = (step_i == 3'd5);
        unique case (step_i)
          3'd0, 3'd3: begin addr_o = A_UL_A; data_o = D_UL_A;   end
          3'd1, 3'd4: begin addr_o = A_UL_B; data_o = D_UL_B;   end
          3'd2:       begin addr_o = A_UL_A; data_o = D_ER_SET; end
          default:    begin addr_o = '0;     data_o = D_ER_GO;  end
        endcase
      end
      SEQ_PROG: begin
        last_o = (step_i == 3'd3);
        unique case (step_i)
          3'd0:    begin addr_o = A_UL_A;     data_o = D_UL_A;     end
          3'd1:    begin addr_o = A_UL_B;     data_o = D_UL_B;     end
          3'd2:    begin addr_o = A_UL_A;     data_o = D_PG_SET;   end
          default: begin addr_o = tgt_addr_i; data_o = tgt_data_i; end
        endcase
      end
      default: begin addr_o = '0; data_o = D_RESET; last_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/fbp_gap_timer.sv
module fbp_gap_timer #(
  parameter int GAP_CYCLES = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= GW'(GAP_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0) && !load_i;
endmodule

// File: rtl/fbp_poll_ctr.sv
module fbp_poll_ctr #(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // the pair being judged now is the last one allowed
  assign at_limit_o = (cnt_q == PW'(POLL_LIMIT - 1));
endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import fbp_pkg::*;
#(
  parameter int AW         = 13,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_BYTES = 8192,
  parameter int CLK_MHZ    = 125,
  parameter int GAP_NS     = 1000,
  parameter int POLL_LIMIT = 1000000,
  localparam int BSW        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BW         = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
  localparam int GAP_CYCLES = (CLK_MHZ * GAP_NS + 999) / 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BSW-1:0]     bank_i,
  output logic [BW-1:0]      img_addr_o,
  input  logic [7:0]         img_data_i,
  output logic [BSW+AW-1:0]  fl_addr_o,
  output logic [7:0]         fl_wdata_o,
  output logic               fl_we_o,
  output logic               fl_oe_o,
  input  logic [7:0]         fl_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic               verify_fail_o
);
  localparam logic [BW-1:0] LAST_BYTE = BW'(BANK_BYTES - 1);

  state_e         state_q;
  seq_e           seq_q;
  logic           prog_phase_q;
  logic [2:0]     step_q;
  logic [BW-1:0]  byte_q;
  logic [BSW-1:0] bank_q;
  logic [7:0]     rd0_q;
  logic           timeout_q, fail_q;

  logic [AW-1:0]  cmd_addr;
  logic [7:0]     cmd_data;
  logic           cmd_last;
  logic           gap_done, poll_at_limit;
  logic           pair_equal, vfy_mismatch;
  logic [7:0]     vfy_expect;

  fbp_cmd_seq #(.AW(AW)) u_seq (
    .seq_i      (seq_q),
    .step_i     (step_q),
    .tgt_addr_i (AW'(byte_q)),
    .tgt_data_i (img_data_i),
    .addr_o     (cmd_addr),
    .data_o     (cmd_data),
    .last_o     (cmd_last)
  );

  fbp_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_CMD),
    .expired_o (gap_done)
  );

  fbp_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == ST_CMD),
    .inc_i      (state_q == ST_POLL_B && !pair_equal),
    .at_limit_o (poll_at_limit)
  );

  assign pair_equal   = (fl_rdata_i == rd0_q);
  assign vfy_expect   = prog_phase_q ? img_data_i : D_BLANK;
  assign vfy_mismatch = (fl_rdata_i != vfy_expect);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      seq_q        <= SEQ_ERASE;
      prog_phase_q <= 1'b0;
      step_q       <= '0;
      byte_q       <= '0;
      bank_q       <= '0;
      rd0_q        <= '0;
      timeout_q    <= 1'b0;
      fail_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          bank_q       <= bank_i;
          seq_q        <= SEQ_ERASE;
          prog_phase_q <= 1'b0;
          step_q       <= '0;
          byte_q       <= '0;
          timeout_q    <= 1'b0;
          fail_q       <= 1'b0;
          state_q      <= ST_CMD;
        end
        ST_CMD: state_q <= ST_GAP;
        ST_GAP: if (gap_done) begin
          if (!cmd_last) begin
            step_q  <= step_q + 3'd1;
            state_q <= ST_CMD;
          end else if (seq_q == SEQ_RESET) begin
            byte_q  <= '0;
            state_q <= ST_VERIFY;
          end else begin
            state_q <= ST_POLL_A;
          end
        end
        ST_POLL_A: begin
          rd0_q   <= fl_rdata_i;
          state_q <= ST_POLL_B;
        end
        ST_POLL_B: begin
          if (pair_equal) begin
            step_q  <= '0;
            state_q <= ST_CMD;
            if (seq_q == SEQ_PROG && byte_q != LAST_BYTE) byte_q <= byte_q + 1'b1;
            else seq_q <= SEQ_RESET;
          end else if (poll_at_limit) begin
            timeout_q <= 1'b1;
            seq_q     <= SEQ_RESET;
            step_q    <= '0;
            state_q   <= ST_CMD;
          end else begin
            state_q <= ST_POLL_A;
          end
        end
        ST_VERIFY: begin
          if (vfy_mismatch) fail_q <= 1'b1;
          if (byte_q != LAST_BYTE) begin
            byte_q <= byte_q + 1'b1;
          end else if (!prog_phase_q && !fail_q && !vfy_mismatch) begin
            prog_phase_q <= 1'b1;
            seq_q        <= SEQ_PROG;
            byte_q       <= '0;
            step_q       <= '0;
            state_q      <= ST_CMD;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_addr_o = {bank_q, {AW{1'b0}}};
    if (state_q == ST_CMD)         fl_addr_o = {bank_q, cmd_addr};
    else if (state_q == ST_VERIFY) fl_addr_o = {bank_q, AW'(byte_q)};
  end

  assign fl_wdata_o    = cmd_data;
  assign fl_we_o       = (state_q == ST_CMD);
  assign fl_oe_o       = (state_q == ST_POLL_A) || (state_q == ST_POLL_B) ||
                         (state_q == ST_VERIFY);
  assign img_addr_o    = byte_q;
  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o        = (state_q == ST_DONE);
  assign timeout_o     = timeout_q;
  assign verify_fail_o = fail_q;
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int AW         = 13,
  parameter int BSW        = 1,
  parameter int GAP_CYCLES = 125
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [BSW-1:0]    bank_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fl_we_o,
  input logic              fl_oe_o,
  input logic [BSW+AW-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [AW-1:0] A_UL_A = AW'(12'h555);
  localparam logic [AW-1:0] A_UL_B = AW'(12'h2AA);

  logic [GW-1:0]  since_wr_q;
  logic [BSW-1:0] bank_q;
  logic [AW-1:0]  p1_addr_q, p2_addr_q;
  logic [7:0]     p1_data_q, p2_data_q;
  logic [AW-1:0]  off;

  assign off = fl_addr_o[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_wr_q <= GW'(GAP_CYCLES);
      bank_q     <= '0;
      p1_addr_q  <= '0;
      p2_addr_q  <= '0;
      p1_data_q  <= '0;
      p2_data_q  <= '0;
    end else begin
      if (fl_we_o) since_wr_q <= '0;
      else if (since_wr_q < GW'(GAP_CYCLES)) since_wr_q <= since_wr_q + 1'b1;
      if (start_i && !busy_o) bank_q <= bank_i;
      if (fl_we_o) begin
        p1_addr_q <= off;        p1_data_q <= fl_wdata_o;
        p2_addr_q <= p1_addr_q;  p2_data_q <= p1_data_q;
      end
    end
  end

  assert_unlock_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o && off == A_UL_A && (fl_wdata_o == 8'h80 || fl_wdata_o == 8'hA0) |->
      p1_addr_q == A_UL_B && p1_data_q == 8'h55 &&
      p2_addr_q == A_UL_A && p2_data_q == 8'hAA);

  assert_bank_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (fl_we_o || fl_oe_o) |-> fl_addr_o[BSW+AW-1:AW] == bank_q);

  assert_write_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> since_wr_q >= GW'(GAP_CYCLES));

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_oe_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !fl_we_o && !fl_oe_o);
endmodule

bind flash_bank_prog fbp_checker #(.AW(AW), .BSW(BSW), .GAP_CYCLES(GAP_CYCLES)) u_fbp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .bank_i     (bank_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fl_we_o    (fl_we_o),
  .fl_oe_o    (fl_oe_o),
  .fl_addr_o  (fl_addr_o),
  .fl_wdata_o (fl_wdata_o)
);

// File: tb/flash_bank_prog_bench.sv
module flash_bank_prog_bench;
  localparam int AW = 13, BYTES = 16, GAP = 3, LIMIT = 20, BUSY_RD = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [0:0] bank_i = '0;
  logic [3:0] img_addr_o;
  logic [7:0] img_data_i, fl_wdata_o, fl_rdata_i;
  logic [AW:0] fl_addr_o;
  logic fl_we_o, fl_oe_o, busy_o, done_o, timeout_o, verify_fail_o;
  logic [7:0] seed = 8'd0;

  always #4 clk = ~clk;

  flash_bank_prog #(.AW(AW), .NUM_BANKS(2), .BANK_BYTES(BYTES), .CLK_MHZ(125),
                    .GAP_NS(24), .POLL_LIMIT(LIMIT)) u_flash_bank_prog (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .bank_i(bank_i),
    .img_addr_o(img_addr_o), .img_data_i(img_data_i),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_we_o(fl_we_o),
    .fl_oe_o(fl_oe_o), .fl_rdata_i(fl_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .verify_fail_o(verify_fail_o));

  function automatic logic [7:0] img_byte(input int i, input logic [7:0] sd);
    return (8'(i) * 8'd29 + sd) & 8'h7F;
  endfunction
  assign img_data_i = img_byte(int'(img_addr_o), seed);

  // ---------------- flash model ----------------
  logic [7:0] mem [2][BYTES];
  int cst = 0, busy_cnt = 0, since = 1000;
  logic stuck_busy = 1'b0, tog = 1'b0;
  int proto_err = 0, gap_err = 0, busy_wr_err = 0, prog_cnt = 0, rst_cnt = 0, erase_cnt = 0;
  logic clr = 1'b0, preload = 1'b0, erase_bad = 1'b0;
  int stuck_at = -1, prog_bad_at = -1;
  logic model_busy;
  logic bk;
  logic [AW-1:0] off;

  assign model_busy = (busy_cnt != 0) || stuck_busy;
  assign bk  = fl_addr_o[AW];
  assign off = fl_addr_o[AW-1:0];
  assign fl_rdata_i = model_busy ? (8'h80 | {1'b0, tog, 6'h0}) : mem[bk][off[3:0]];

  always @(posedge clk) begin
    if (clr) begin
      proto_err <= 0; gap_err <= 0; busy_wr_err <= 0; prog_cnt <= 0;
      rst_cnt <= 0; erase_cnt <= 0; busy_cnt <= 0; stuck_busy <= 1'b0; cst <= 0;
      if (preload)
        for (int i = 0; i < BYTES; i++) begin
          mem[0][i] <= 8'h00;
          mem[1][i] <= 8'h3C;
        end
    end else begin
      if (fl_we_o) begin
        if (since < GAP) gap_err <= gap_err + 1;
        since <= 0;
        if (fl_wdata_o == 8'hF0) begin
          rst_cnt <= rst_cnt + 1;
          if (off != 0) proto_err <= proto_err + 1;
          busy_cnt <= 0; stuck_busy <= 1'b0; cst <= 0;
        end else if (model_busy) begin
          busy_wr_err <= busy_wr_err + 1;
        end else begin
          case (cst)
            0: if (off == 13'h555 && fl_wdata_o == 8'hAA) cst <= 1;
               else begin proto_err <= proto_err + 1; cst <= 0; end
            1: if (off == 13'h2AA && fl_wdata_o == 8'h55) cst <= 2;
               else begin proto_err <= proto_err + 1; cst <= 0; end
            2: if (off == 13'h555 && fl_wdata_o == 8'h80) cst <= 3;
               else if (off == 13'h555 && fl_wdata_o == 8'hA0) cst <= 6;
               else begin proto_err <= proto_err + 1; cst <= 0; end
            3: if (off == 13'h555 && fl_wdata_o == 8'hAA) cst <= 4;
               else begin proto_err <= proto_err + 1; cst <= 0; end
            4: if (off == 13'h2AA && fl_wdata_o == 8'h55) cst <= 5;
               else begin proto_err <= proto_err + 1; cst <= 0; end
            5: begin
              if (off == 0 && fl_wdata_o == 8'h30) begin
                for (int i = 0; i < BYTES; i++)
                  mem[bk][i] <= (erase_bad && i == 3) ? 8'h12 : 8'hFF;
                erase_cnt <= erase_cnt + 1;
                busy_cnt  <= BUSY_RD;
              end else proto_err <= proto_err + 1;
              cst <= 0;
            end
            6: begin
              if (off < BYTES) begin
                mem[bk][off[3:0]] <= (prog_bad_at == prog_cnt) ? fl_wdata_o ^ 8'h01 : fl_wdata_o;
                if (stuck_at == prog_cnt) stuck_busy <= 1'b1;
                else busy_cnt <= BUSY_RD;
                prog_cnt <= prog_cnt + 1;
              end else proto_err <= proto_err + 1;
              cst <= 0;
            end
            default: cst <= 0;
          endcase
        end
      end else if (since < 1000) since <= since + 1;
      if (fl_oe_o && model_busy) begin
        tog <= ~tog;
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic model_setup(input logic pre, input logic ebad, input int pbad, input int stk);
    @(negedge clk);
    preload = pre; erase_bad = ebad; prog_bad_at = pbad; stuck_at = stk; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; preload = 1'b0;
  endtask

  task automatic run_job(input logic bnk, input logic [7:0] sd, input logic poke);
    int cyc;
    @(negedge clk);
    seed = sd; bank_i = bnk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    chk(timeout_o == 1'b0 && verify_fail_o == 1'b0, "R10 flags cleared on start",
        {timeout_o, verify_fail_o}, 0);
    cyc = 0;
    while (!done_o && cyc < 20000) begin
      if (poke && cyc == 40) begin bank_i = ~bnk; start_i = 1'b1; end
      else begin start_i = 1'b0; bank_i = bnk; end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R10 done reached", done_o, 1);
  endtask

  task automatic check_after_done();
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R10 done one cycle", {done_o, busy_o}, 0);
  endtask

  task automatic check_bank(input logic bnk, input logic [7:0] sd, input string req);
    for (int i = 0; i < BYTES; i++)
      chk(mem[bnk][i] == img_byte(i, sd), req, mem[bnk][i], img_byte(i, sd));
  endtask

  task automatic check_good_job(input logic bnk, input logic [7:0] sd);
    chk(timeout_o == 1'b0, "R6 no timeout", timeout_o, 0);
    chk(verify_fail_o == 1'b0, "R9 verify clean", verify_fail_o, 0);
    chk(proto_err == 0, "R1 unlock protocol", proto_err, 0);
    chk(erase_cnt == 1, "R2 one erase", erase_cnt, 1);
    chk(prog_cnt == BYTES, "R3 bytes programmed", prog_cnt, BYTES);
    chk(gap_err == 0, "R4 write spacing", gap_err, 0);
    chk(busy_wr_err == 0, "R5 no write while busy", busy_wr_err, 0);
    chk(rst_cnt == 2, "R7 reset writes", rst_cnt, 2);
    check_bank(bnk, sd, "R3 bank contents");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R10 reset idle", {busy_o, done_o}, 0);
    chk(fl_we_o == 1'b0 && fl_oe_o == 1'b0, "R10 reset strobes", {fl_we_o, fl_oe_o}, 0);
    chk(timeout_o == 1'b0 && verify_fail_o == 1'b0, "R10 reset flags",
        {timeout_o, verify_fail_o}, 0);
    rst_ni = 1'b1;

    // normal job on bank 0; stray start mid-run must be ignored (R10)
    model_setup(1'b1, 1'b0, -1, -1);
    run_job(1'b0, 8'h05, 1'b1);
    check_good_job(1'b0, 8'h05);
    for (int i = 0; i < BYTES; i++)
      chk(mem[1][i] == 8'h3C, "R3 R10 other bank untouched", mem[1][i], 8'h3C);
    check_after_done();

    // normal job on bank 1
    model_setup(1'b0, 1'b0, -1, -1);
    run_job(1'b1, 8'h21, 1'b0);
    check_good_job(1'b1, 8'h21);
    check_bank(1'b0, 8'h05, "R3 bank 0 kept");
    check_after_done();

    // erase leaves a stuck byte: fail, program skipped
    model_setup(1'b0, 1'b1, -1, -1);
    run_job(1'b0, 8'h33, 1'b0);
    chk(verify_fail_o == 1'b1, "R8 erase verify fail", verify_fail_o, 1);
    chk(prog_cnt == 0, "R8 program skipped", prog_cnt, 0);
    chk(rst_cnt == 1, "R7 single reset", rst_cnt, 1);
    chk(timeout_o == 1'b0, "R6 no timeout on erase fail", timeout_o, 0);
    chk(mem[0][3] == 8'h12, "R8 bad byte left", mem[0][3], 8'h12);

    // one programmed byte corrupted
    model_setup(1'b0, 1'b0, 5, -1);
    run_job(1'b1, 8'h47, 1'b0);
    chk(verify_fail_o == 1'b1, "R9 program verify fail", verify_fail_o, 1);
    chk(prog_cnt == BYTES, "R9 all bytes attempted", prog_cnt, BYTES);
    chk(timeout_o == 1'b0, "R6 no timeout on mismatch", timeout_o, 0);

    // flash hangs on byte 7
    model_setup(1'b0, 1'b0, -1, 7);
    run_job(1'b0, 8'h11, 1'b0);
    chk(timeout_o == 1'b1, "R6 timeout raised", timeout_o, 1);
    chk(prog_cnt == 8, "R6 program aborted", prog_cnt, 8);
    chk(verify_fail_o == 1'b1, "R9 aborted image mismatch", verify_fail_o, 1);
    chk(rst_cnt == 2, "R7 reset after abort", rst_cnt, 2);
    chk(busy_wr_err == 0, "R5 no write while hung", busy_wr_err, 0);
    chk(mem[0][8] == 8'hFF, "R6 byte after abort blank", mem[0][8], 8'hFF);

    // flags clear and job succeeds again
    model_setup(1'b0, 1'b0, -1, -1);
    run_job(1'b0, 8'h6A, 1'b0);
    check_good_job(1'b0, 8'h6A);
    check_after_done();

    summary();
  end
endmodule